// File: doc/BRIEF.md
# Banked Vector Register File

This block stores 128 registers of 64 bits each and serves several read and write requesters at once without a true multi-ported array. Storage is split into eight banks. Each bank is a plain array with one read port and one write port. A register belongs to exactly one bank, and the low three bits of its 7-bit number select that bank. The remaining four bits select the row inside the bank.

There are four read request ports and two write request ports. In every cycle, each bank grants at most one read and at most one write. A requester that loses sees its ready signal low in the same cycle and must hold its request until it is granted. Read data comes back one cycle after the grant, on the data lane of the port that asked for it, and is marked by that lane's valid bit.

Each bank has an enable output. The enable is high only in a cycle in which the bank performs a read or a write, so an idle bank can be clock gated. Reset clears the handshake state and the read-return state. Reset leaves the register contents untouched.

Top module: `vrf_banked`

## Requirements
- R1: Every one of the 128 registers holds a 64-bit value. A value written to a register is returned unchanged by a later read of that register.
- R2: Register number n maps to bank n[2:0] and row n[6:3]. bank_en bit k (bit 0 = bank 0) corresponds to bank k.
- R3: When several read ports target the same bank in one cycle, only the lowest-numbered of them sees rd_ready high. A port that holds its request is served once all lower-numbered contenders have withdrawn.
- R4: When both write ports target the same bank in one cycle, only write port 0 sees wr_ready high. The losing write has no effect on storage.
- R5: Requests that fall in distinct banks are all granted in the same cycle. A bank can accept one read and one write together.
- R6: A read granted in cycle t drives rd_data_valid for that port high in cycle t+1, with the data on lane p (bits p*64 and up). A port with no grant has its valid low in the next cycle.
- R7: A read and a write to the same register granted in the same cycle return the value held before the write. The new value is returned by a later read.
- R8: bank_en[k] is high in a cycle exactly when a granted read or write targets bank k. Otherwise it is low.
- R9: While rst_n is low, no ready and no bank enable is asserted, whatever the requests. After reset, rd_data_valid is low. Register contents written before reset survive it.
- R10: With no valid request on any port, all ready outputs and all bank enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 4 | Read request valid, one bit per read port |
| rd_addr | input | 28 | Register number per read port, 7 bits each, port p at bits 7p and up |
| rd_ready | output | 1x4 | Read grant in the request cycle, one bit per port |
| rd_data_valid | output | 4 | Read data present on the port's lane this cycle |
| rd_data | output | 256 | Read data, 64 bits per port, port p at bits 64p and up |
| wr_valid | input | 2 | Write request valid, one bit per write port |
| wr_addr | input | 14 | Register number per write port, 7 bits each |
| wr_data | input | 128 | Write data, 64 bits per port |
| wr_ready | output | 2 | Write grant in the request cycle |
| bank_en | output | 8 | Per-bank access enable for clock gating |

## Verification
The bench first fills all 128 registers in pairs that fall in different banks. It then reads every register back with the port-to-register mapping rotated, so a wrong bank or row split shows up as wrong data or as a wrong enable bit. It sends all four read ports into one bank and withdraws each winner in turn. An arbiter with the wrong priority, or one that grants twice, would show the wrong ready pattern or a second enabled access. Both writes are aimed at one bank, once at the same register and once at different rows. A design that lets the loser through would corrupt a register that is read back later. Two further cases cover a same-cycle read and write of one register, where a bypass would return the new value too early, and a reset in the middle of traffic, where storage that is cleared or grants that leak through reset are caught.

// File: rtl/vrf_pkg.sv
// Package vrf_pkg
// Purpose: default sizing constants shared by the banked register file.
// Assumes: register count and bank count are powers of two.
package vrf_pkg;
    localparam int VRF_NREG_DEF  = 128;
    localparam int VRF_DW_DEF    = 64;
    localparam int VRF_NBANK_DEF = 8;
    localparam int VRF_NRD_DEF   = 4;
    localparam int VRF_NWR_DEF   = 2;
endpackage

// File: rtl/vrf_prio_arb.sv
// Module vrf_prio_arb
// Purpose: fixed-priority arbiter. The lowest-indexed active request wins.
// Assumes: purely combinational grant. The clock and reset are used only by the checks.
module vrf_prio_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // pick the lowest-indexed request
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    assign any = |gnt;

    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R3
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R5
    req_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> any);

    for (genvar i = 1; i < N; i++) begin : g_prio
        // R3
        lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |-> (req[i-1:0] == '0));
    end
endmodule

// File: rtl/vrf_bank.sv
// Module vrf_bank
// Purpose: one bank of the register file, with one read and one write per cycle.
// Assumes: read data is registered. A read and a write to the same row in the
// same cycle return the old content. The array has no reset.
module vrf_bank #(
    parameter int ROWS = 16,
    parameter int DW   = 64,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          re,
    input  logic [RW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [ROWS];

    // registered read of the pre-write content
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

    // write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/vrf_banked.sv
// Module vrf_banked
// Purpose: register file built from interleaved 1R1W banks. Each bank arbitrates
// among the read ports and among the write ports, stalls the losers, returns
// read data one cycle later on the requester's lane, and drives an enable for gating.
// Assumes: requesters hold a request until ready is seen. Reset leaves storage intact.
module vrf_banked
    import vrf_pkg::*;
#(
    parameter int NREG  = VRF_NREG_DEF,
    parameter int DW    = VRF_DW_DEF,
    parameter int NBANK = VRF_NBANK_DEF,
    parameter int NRD   = VRF_NRD_DEF,
    parameter int NWR   = VRF_NWR_DEF,
    localparam int AW   = $clog2(NREG),
    localparam int BW   = $clog2(NBANK),
    localparam int ROWS = NREG / NBANK,
    localparam int RW   = AW - BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRD-1:0]    rd_valid,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD-1:0]    rd_ready,
    output logic [NRD-1:0]    rd_data_valid,
    output logic [NRD*DW-1:0] rd_data,
    input  logic [NWR-1:0]    wr_valid,
    input  logic [NWR*AW-1:0] wr_addr,
    input  logic [NWR*DW-1:0] wr_data,
    output logic [NWR-1:0]    wr_ready,
    output logic [NBANK-1:0]  bank_en
);
    logic [BW-1:0] rbank [NRD];
    logic [RW-1:0] rrow  [NRD];
    logic [BW-1:0] wbank [NWR];
    logic [RW-1:0] wrow  [NWR];
    logic [DW-1:0] wdat  [NWR];

    logic [NRD-1:0] rreq [NBANK];
    logic [NRD-1:0] rgnt [NBANK];
    logic [NWR-1:0] wreq [NBANK];
    logic [NWR-1:0] wgnt [NBANK];
    logic [NBANK-1:0] rany, wany;
    logic [DW-1:0] bank_rdata [NBANK];
    logic [BW-1:0] rsel_q [NRD];

    // split read addresses into bank and row
    for (genvar p = 0; p < NRD; p++) begin : g_rsplit
        assign rbank[p] = rd_addr[p*AW +: BW];
        assign rrow[p]  = rd_addr[p*AW+BW +: RW];
    end

    // split write addresses into bank, row and data
    for (genvar p = 0; p < NWR; p++) begin : g_wsplit
        assign wbank[p] = wr_addr[p*AW +: BW];
        assign wrow[p]  = wr_addr[p*AW+BW +: RW];
        assign wdat[p]  = wr_data[p*DW +: DW];
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [RW-1:0] sel_rrow, sel_wrow;
        logic [DW-1:0] sel_wdat;

        // gather the requests aimed at this bank (none during reset)
        always_comb begin
            for (int p = 0; p < NRD; p++)
                rreq[b][p] = rst_n && rd_valid[p] && (rbank[p] == BW'(b));
            for (int p = 0; p < NWR; p++)
                wreq[b][p] = rst_n && wr_valid[p] && (wbank[p] == BW'(b));
        end

        vrf_prio_arb #(.N(NRD)) u_rarb (
            .clk(clk), .rst_n(rst_n), .req(rreq[b]), .gnt(rgnt[b]), .any(rany[b]));
        vrf_prio_arb #(.N(NWR)) u_warb (
            .clk(clk), .rst_n(rst_n), .req(wreq[b]), .gnt(wgnt[b]), .any(wany[b]));

        // route the winning row and data to the bank
        always_comb begin
            sel_rrow = '0;
            sel_wrow = '0;
            sel_wdat = '0;
            for (int p = 0; p < NRD; p++)
                if (rgnt[b][p]) sel_rrow = rrow[p];
            for (int p = 0; p < NWR; p++)
                if (wgnt[b][p]) begin
                    sel_wrow = wrow[p];
                    sel_wdat = wdat[p];
                end
        end

        vrf_bank #(.ROWS(ROWS), .DW(DW)) u_bank (
            .clk(clk), .re(rany[b]), .raddr(sel_rrow), .rdata(bank_rdata[b]),
            .we(wany[b]), .waddr(sel_wrow), .wdata(sel_wdat));

        assign bank_en[b] = rany[b] | wany[b];

        // R8
        en_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_en[b] |-> ((|rreq[b]) || (|wreq[b])));
    end

    // merge the per-bank grants into per-port ready
    always_comb begin
        rd_ready = '0;
        wr_ready = '0;
        for (int b = 0; b < NBANK; b++) begin
            rd_ready = rd_ready | rgnt[b];
            wr_ready = wr_ready | wgnt[b];
        end
    end

    // remember which bank each granted read came from
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_valid <= '0;
        end else begin
            rd_data_valid <= rd_ready;
            for (int p = 0; p < NRD; p++)
                if (rd_ready[p]) rsel_q[p] <= rbank[p];
        end
    end

    // return data on the requester's lane
    for (genvar p = 0; p < NRD; p++) begin : g_ret
        assign rd_data[p*DW +: DW] = bank_rdata[rsel_q[p]];

        // R6
        ret_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ready[p] |=> rd_data_valid[p]);
        // R6
        no_ret_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_ready[p] |=> !rd_data_valid[p]);
        // R10
        ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ready[p] |-> rd_valid[p]);
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data_valid == '0));
endmodule

// File: tb/vrf_banked_test.sv
module vrf_banked_test;
    localparam int CLK_PERIOD = 10;
    localparam int NRD = 4;
    localparam int NWR = 2;
    localparam int AW  = 7;
    localparam int DW  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NRD-1:0]    rd_valid = '0;
    logic [NRD*AW-1:0] rd_addr = '0;
    logic [NRD-1:0]    rd_ready;
    logic [NRD-1:0]    rd_data_valid;
    logic [NRD*DW-1:0] rd_data;
    logic [NWR-1:0]    wr_valid = '0;
    logic [NWR*AW-1:0] wr_addr = '0;
    logic [NWR*DW-1:0] wr_data = '0;
    logic [NWR-1:0]    wr_ready;
    logic [7:0]        bank_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    vrf_banked uut (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data_valid(rd_data_valid), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .bank_en(bank_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] dat(int i, int s);
        return {8'(i), 24'h3C96A5, 8'(255 - i), 24'(i * 37 + s * 1001)};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear();
        rd_valid = '0;
        wr_valid = '0;
    endtask

    task automatic set_rd(int p, int a);
        rd_valid[p] = 1'b1;
        rd_addr[p*AW +: AW] = AW'(a);
    endtask

    task automatic set_wr(int p, int a, logic [63:0] d);
        wr_valid[p] = 1'b1;
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*DW +: DW] = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int regs [4];
        logic [3:0] msk;
        logic [7:0] en_exp;

        // R9: requests during reset are ignored
        repeat (2) @(negedge clk);
        set_rd(0, 0); set_rd(1, 1); set_wr(0, 2, 64'h1); set_wr(1, 3, 64'h2);
        #1;
        check("R9 rd_ready in reset", 64'(rd_ready), 64'h0);
        check("R9 wr_ready in reset", 64'(wr_ready), 64'h0);
        check("R9 bank_en in reset", 64'(bank_en), 64'h0);
        @(negedge clk);
        clear();
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 data_valid after reset", 64'(rd_data_valid), 64'h0);
        #1;
        check("R10 idle ready", 64'({rd_ready, wr_ready}), 64'h0);
        check("R10 idle bank_en", 64'(bank_en), 64'h0);

        // R1 R2 R5: fill every register, two banks per cycle
        for (int i = 0; i < 128; i += 2) begin
            @(negedge clk);
            set_wr(0, i, dat(i, 0));
            set_wr(1, i + 1, dat(i + 1, 0));
            #1;
            check("R5 both writes granted", 64'(wr_ready), 64'h3);
            check("R2 write bank_en", 64'(bank_en),
                  64'((8'd1 << (i % 8)) | (8'd1 << ((i + 1) % 8))));
        end
        @(negedge clk);
        clear();

        // R1 R2 R6: read all back with rotated port mapping
        for (int i = 0; i < 128; i += 4) begin
            @(negedge clk);
            check("R6 no stale data_valid", 64'(rd_data_valid), 64'h0);
            en_exp = '0;
            for (int p = 0; p < NRD; p++) begin
                regs[p] = i + ((p + i / 4) % 4);
                set_rd(p, regs[p]);
                en_exp[regs[p] % 8] = 1'b1;
            end
            #1;
            check("R5 four reads granted", 64'(rd_ready), 64'hF);
            check("R2 read bank_en", 64'(bank_en), 64'(en_exp));
            @(negedge clk);
            clear();
            check("R6 data_valid", 64'(rd_data_valid), 64'hF);
            for (int p = 0; p < NRD; p++)
                check("R1 read back", rd_data[p*DW +: DW], dat(regs[p], 0));
        end

        // R3: four reads into bank 3, winners withdraw one by one
        @(negedge clk);
        msk = 4'hF;
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < NRD; p++)
                if (msk[p]) set_rd(p, 3 + 8 * p); else rd_valid[p] = 1'b0;
            #1;
            check("R3 lowest read wins", 64'(rd_ready), 64'(4'b1 << c));
            check("R8 single bank enabled", 64'(bank_en), 64'h08);
            @(negedge clk);
            check("R3 served port data_valid", 64'(rd_data_valid), 64'(4'b1 << c));
            check("R3 served port data", rd_data[c*DW +: DW], dat(3 + 8 * c, 0));
            msk[c] = 1'b0;
        end
        clear();

        // R4: both writes to register 5
        @(negedge clk);
        set_wr(0, 5, 64'hAAAA_0000_1111_0005);
        set_wr(1, 5, 64'h5555_FFFF_EEEE_0005);
        #1;
        check("R4 write port 0 wins", 64'(wr_ready), 64'h1);
        @(negedge clk);
        clear();
        set_rd(2, 5);
        @(negedge clk);
        clear();
        check("R4 winner data stored", rd_data[2*DW +: DW], 64'hAAAA_0000_1111_0005);

        // R4: same bank, different rows; loser must not write
        set_wr(0, 5, dat(5, 0));
        set_wr(1, 13, 64'hDEAD_BEEF_0000_000D);
        #1;
        check("R4 same-bank loser stalled", 64'(wr_ready), 64'h1);
        @(negedge clk);
        clear();
        set_rd(0, 13);
        @(negedge clk);
        clear();
        check("R4 loser had no effect", rd_data[0 +: DW], dat(13, 0));

        // R7: read and write of register 9 in one cycle
        set_wr(1, 9, 64'h0123_4567_89AB_CDEF);
        set_rd(1, 9);
        #1;
        check("R5 read and write same bank", 64'({rd_ready, wr_ready}), 64'({4'b0010, 2'b10}));
        check("R8 one bank for rw", 64'(bank_en), 64'h02);
        @(negedge clk);
        clear();
        check("R7 old value returned", rd_data[1*DW +: DW], dat(9, 0));
        set_rd(3, 9);
        @(negedge clk);
        clear();
        check("R7 new value later", rd_data[3*DW +: DW], 64'h0123_4567_89AB_CDEF);

        // R9: reset mid-traffic keeps storage
        rst_n = 1'b0;
        set_rd(0, 20);
        #1;
        check("R9 ready blocked in reset", 64'(rd_ready), 64'h0);
        check("R9 bank_en blocked in reset", 64'(bank_en), 64'h0);
        @(negedge clk);
        clear();
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 data_valid low after reset", 64'(rd_data_valid), 64'h0);
        set_rd(0, 20);
        @(negedge clk);
        clear();
        check("R9 storage survives reset", rd_data[0 +: DW], dat(20, 0));
        @(negedge clk);
        check("R10 final idle", 64'({rd_ready, wr_ready, bank_en}), 64'h0);

        finish_run();
    end
endmodule